// File: doc/BRIEF.md
# Bus access fault classifier

This block watches every access presented on the system bus. For each one it decides whether the access breaks a rule, and it sorts any violation into one of a few causes. The inputs are the address, the transfer size, a write flag, a privilege flag and a valid strobe. The address map is fixed at build time through parameters. These give the 4 kB windows of the register peripherals, the last implemented register offset inside each window, which windows hold system peripherals, a protected RAM range, and the populated top of the RAM and flash spaces.

Each cause has its own bit in a sticky status register. A single access may set several bits at once. A fault that arrives while any bit is still set also sets a separate missed bit. Software clears bits by presenting a mask with ones in the positions to clear. When a faulting access arrives while the status is all zero, a one-cycle pulse goes out so that an exception can be raised.

Top module: `bus_fault_classifier`

## Requirements
- R1: While reset is high and on the first cycle after it, `fault_status` is 0 and `fault_pulse` is 0.
- R2: A byte (`acc_size`=0) or halfword (`acc_size`=1) access whose address lies in any peripheral window sets status bit 0 (size fault).
- R3: An unaligned access sets status bit 0 at any address. A word (`acc_size`=2, and 3 is treated as word) is unaligned when `acc_addr[1:0]` is nonzero. A halfword is unaligned when `acc_addr[0]` is 1.
- R4: An unprivileged (`acc_priv`=0) write to a system peripheral window, or to the protected RAM range, sets status bit 1 (privilege fault).
- R5: Reads never set bit 1, whatever the privilege level. Privileged writes never set bit 1.
- R6: An access inside a peripheral window, at a byte offset above that window's last implemented register, sets status bit 2 (hole fault).
- R7: An access inside the RAM space above the populated RAM top, or inside the flash space above the populated flash top, sets status bit 2.
- R8: When one access breaks several rules, every matching bit is set on the same clock edge.
- R9: A faulting access that is sampled while `fault_status` is nonzero also sets status bit 3 (missed). This applies even when the same cycle clears those bits.
- R10: Status bits hold until cleared. When `clr_en` is 1, each bit whose `clr_mask` bit is 1 is cleared. If a clear and a new set hit the same bit on the same edge, the bit ends up set.
- R11: `fault_pulse` is high for exactly the one cycle after the edge that samples a faulting access while `fault_status` was zero. Idle cycles, clean accesses and faults that arrive while the status is nonzero produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_priv | input | 1 | 1 when the access is privileged |
| clr_en | input | 1 | Apply `clr_mask` this cycle |
| clr_mask | input | 4 | Ones clear the matching status bits |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_status | output | 4 | Sticky status: bit0 size, bit1 privilege, bit2 hole, bit3 missed |

## Verification
The hardest cases to reach from the ports are the collisions. One is a single access that breaks three rules at once. Another is a second fault that lands on the same edge as a software clear, which must both keep the new bits and raise the missed bit. The stimulus builds the first as an unprivileged byte write past the last register of a system peripheral window. It builds the second by holding a fault in the status and then sending, in one cycle, a clear of all bits together with a fresh faulting access. A seeded random phase then mixes boundary addresses, sizes and clears, with a behavioural model checked on every clock.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_WRSV = 2'd3
    } xfer_size_e;

    localparam int FLAG_W = 4;

    // bit 3 missed, bit 2 hole, bit 1 privilege, bit 0 size
    typedef struct packed {
        logic lost;
        logic hole;
        logic priv;
        logic size;
    } fault_flags_t;

    typedef struct packed {
        logic in_periph;
        logic in_sys;
        logic past_last;
        logic prot_ram;
        logic above_ram;
        logic above_flash;
    } region_t;

    function automatic logic is_word(input xfer_size_e sz);
        return (sz == XFER_WORD) || (sz == XFER_WRSV);
    endfunction

    function automatic logic misaligned(input logic [1:0] lo, input xfer_size_e sz);
        logic r;
        case (sz)
            XFER_HALF: r = lo[0];
            XFER_WORD,
            XFER_WRSV: r = |lo;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bfc_decode.sv
module bfc_decode
    import bus_fault_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WIN_BITS   = 12,
    parameter int NUM_PERIPH = 4,
    parameter logic [NUM_PERIPH*ADDR_W-1:0]   PERIPH_BASE = '0,
    parameter logic [NUM_PERIPH*WIN_BITS-1:0] PERIPH_LAST = '0,
    parameter logic [NUM_PERIPH-1:0]          PERIPH_SYS  = '0,
    parameter logic [ADDR_W-1:0] RAM_TOP     = '0,
    parameter logic [ADDR_W-1:0] RAM_END     = '0,
    parameter logic [ADDR_W-1:0] FLASH_TOP   = '0,
    parameter logic [ADDR_W-1:0] FLASH_END   = '0,
    parameter logic [ADDR_W-1:0] PROT_LO     = '0,
    parameter logic [ADDR_W-1:0] PROT_HI     = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);

    localparam int PAGE_W = ADDR_W - WIN_BITS;

    logic [NUM_PERIPH-1:0] win_hit;
    logic [NUM_PERIPH-1:0] win_over;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_win
        localparam logic [ADDR_W-1:0]   BASE_I = PERIPH_BASE[i*ADDR_W +: ADDR_W];
        localparam logic [WIN_BITS-1:0] LAST_I = PERIPH_LAST[i*WIN_BITS +: WIN_BITS];
        assign win_hit[i]  = (addr[ADDR_W-1 -: PAGE_W] == BASE_I[ADDR_W-1 -: PAGE_W]);
        assign win_over[i] = win_hit[i] && (addr[WIN_BITS-1:0] > LAST_I);
    end

    always_comb begin
        region             = '0;
        region.in_periph   = |win_hit;
        region.in_sys      = |(win_hit & PERIPH_SYS);
        region.past_last   = |win_over;
        region.prot_ram    = (addr >= PROT_LO) && (addr <= PROT_HI);
        region.above_ram   = (addr > RAM_TOP) && (addr <= RAM_END);
        region.above_flash = (addr > FLASH_TOP) && (addr <= FLASH_END);
    end

endmodule

// File: rtl/bfc_rules.sv
module bfc_rules
    import bus_fault_pkg::*;
(
    input  region_t      region,
    input  logic [1:0]   addr_lo,
    input  xfer_size_e   size,
    input  logic         is_write,
    input  logic         is_priv,
    output fault_flags_t flags
);

    logic narrow_periph;
    logic user_store;

    assign narrow_periph = region.in_periph && !is_word(size);
    assign user_store    = is_write && !is_priv;

    always_comb begin
        flags      = '0;
        flags.size = narrow_periph || misaligned(addr_lo, size);
        flags.priv = user_store && (region.in_sys || region.prot_ram);
        flags.hole = region.past_last || region.above_ram || region.above_flash;
        flags.lost = 1'b0;
    end

endmodule

// File: rtl/bfc_status.sv
module bfc_status
    import bus_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_fire,
    input  fault_flags_t      new_flags,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] sts_q,
    output logic              pulse_q
);

    fault_flags_t      hit;
    logic              any_hit;
    logic              was_set;
    logic [FLAG_W-1:0] keep;
    logic [FLAG_W-1:0] sts_d;

    assign hit     = acc_fire ? new_flags : '0;
    assign any_hit = |hit;
    assign was_set = |sts_q;
    assign keep    = clr_en ? (sts_q & ~clr_mask) : sts_q;

    always_comb begin
        fault_flags_t add;
        add      = hit;
        add.lost = any_hit && was_set;
        sts_d    = keep | add;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            sts_q   <= sts_d;
            pulse_q <= any_hit && !was_set;
        end
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        acc_fire |=> ((sts_q & $past(new_flags)) == $past(new_flags)));

    assert_missed_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_fire && (|new_flags) && (sts_q != '0)) |=> sts_q[3]);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    assert_pulse_has_status_R11: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (sts_q != '0));

    assert_idle_no_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_fire |=> !pulse_q);

endmodule

// File: rtl/bus_fault_classifier.sv
module bus_fault_classifier
    import bus_fault_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WIN_BITS   = 12,
    parameter int NUM_PERIPH = 4,
    parameter logic [NUM_PERIPH*ADDR_W-1:0] PERIPH_BASE =
        {32'h4000_3000, 32'h4000_2000, 32'h4000_1000, 32'h4000_0000},
    parameter logic [NUM_PERIPH*WIN_BITS-1:0] PERIPH_LAST =
        {12'h07C, 12'h01C, 12'h0FC, 12'h03C},
    parameter logic [NUM_PERIPH-1:0] PERIPH_SYS = 4'b0011,
    parameter logic [ADDR_W-1:0] RAM_TOP   = 32'h2000_1FFF,
    parameter logic [ADDR_W-1:0] RAM_END   = 32'h2000_FFFF,
    parameter logic [ADDR_W-1:0] FLASH_TOP = 32'h0801_FFFF,
    parameter logic [ADDR_W-1:0] FLASH_END = 32'h080F_FFFF,
    parameter logic [ADDR_W-1:0] PROT_LO   = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] PROT_HI   = 32'h2000_00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              clr_en,
    input  logic [3:0]        clr_mask,
    output logic              fault_pulse,
    output logic [3:0]        fault_status
);

    region_t      region;
    fault_flags_t flags;
    xfer_size_e   size_e;

    assign size_e = xfer_size_e'(acc_size);

    bfc_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_PERIPH(NUM_PERIPH),
        .PERIPH_BASE(PERIPH_BASE), .PERIPH_LAST(PERIPH_LAST), .PERIPH_SYS(PERIPH_SYS),
        .RAM_TOP(RAM_TOP), .RAM_END(RAM_END), .FLASH_TOP(FLASH_TOP),
        .FLASH_END(FLASH_END), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
    ) u_decode (
        .addr   (acc_addr),
        .region (region)
    );

    bfc_rules u_rules (
        .region   (region),
        .addr_lo  (acc_addr[1:0]),
        .size     (size_e),
        .is_write (acc_write),
        .is_priv  (acc_priv),
        .flags    (flags)
    );

    bfc_status u_status (
        .clk       (clk),
        .rst       (rst),
        .acc_fire  (acc_valid),
        .new_flags (flags),
        .clr_en    (clr_en),
        .clr_mask  (clr_mask),
        .sts_q     (fault_status),
        .pulse_q   (fault_pulse)
    );

    assert_reads_no_priv_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (!acc_write || acc_priv) && !fault_status[1]) |=> !fault_status[1]);

    assert_narrow_periph_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && region.in_periph && (acc_size < 2'd2)) |=> fault_status[0]);

    assert_hole_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && region.past_last) |=> fault_status[2]);

endmodule

// File: tb/tb_bus_fault_classifier.sv
`timescale 1ns/1ps
module tb_bus_fault_classifier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr  = '0;
    logic [1:0]  acc_size  = '0;
    logic        acc_write = 1'b0;
    logic        acc_priv  = 1'b0;
    logic        clr_en    = 1'b0;
    logic [3:0]  clr_mask  = '0;
    logic        fault_pulse;
    logic [3:0]  fault_status;

    int    n_chk  = 0;
    int    n_bad  = 0;
    string cur_tag = "R1";
    bit    finished = 0;

    logic [3:0] exp_sts   = '0;
    logic       exp_pulse = 1'b0;

    always #10 clk = ~clk;

    bus_fault_classifier dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_priv(acc_priv),
        .clr_en(clr_en), .clr_mask(clr_mask),
        .fault_pulse(fault_pulse), .fault_status(fault_status)
    );

    function automatic logic [3:0] model_flags(logic [31:0] a, logic [1:0] sz, logic wr, logic pv);
        logic [31:0] bases [4] = '{32'h4000_0000, 32'h4000_1000, 32'h4000_2000, 32'h4000_3000};
        int          lasts [4] = '{'h03C, 'h0FC, 'h01C, 'h07C};
        logic [3:0]  f = '0;
        bit          in_p = 0;
        bit          sys  = 0;
        for (int i = 0; i < 4; i++) begin
            if (a[31:12] == bases[i][31:12]) begin
                in_p = 1;
                if (i < 2) sys = 1;
                if (int'(a[11:0]) > lasts[i]) f[2] = 1'b1;
            end
        end
        if (in_p && sz < 2) f[0] = 1'b1;
        if (sz >= 2 && a[1:0] != 0) f[0] = 1'b1;
        if (sz == 1 && a[0]) f[0] = 1'b1;
        if (!pv && wr && (sys || (a >= 32'h2000_0000 && a <= 32'h2000_00FF))) f[1] = 1'b1;
        if (a > 32'h2000_1FFF && a <= 32'h2000_FFFF) f[2] = 1'b1;
        if (a > 32'h0801_FFFF && a <= 32'h080F_FFFF) f[2] = 1'b1;
        return f;
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cycle(logic v, logic [31:0] a, logic [1:0] sz, logic wr, logic pv,
                         logic ce, logic [3:0] cm);
        logic [3:0] fl;
        logic [3:0] cl;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr; acc_priv = pv;
        clr_en = ce; clr_mask = cm;
        @(posedge clk);
        fl = v ? model_flags(a, sz, wr, pv) : 4'h0;
        cl = ce ? cm : 4'h0;
        exp_pulse = (fl != 0) && (exp_sts == 0);
        if (fl != 0 && exp_sts != 0) fl[3] = 1'b1;
        exp_sts = (exp_sts & ~cl) | fl;
        #5;
        check(cur_tag, fault_status, exp_sts, "status");
        check(cur_tag == "R1" ? "R1" : "R11", {3'b0, fault_pulse}, {3'b0, exp_pulse}, "pulse");
    endtask

    task automatic acc(logic [31:0] a, logic [1:0] sz, logic wr, logic pv);
        cycle(1'b1, a, sz, wr, pv, 1'b0, 4'h0);
    endtask

    task automatic idle();
        cycle(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic clear_all();
        cycle(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #5;
        check("R1", fault_status, 4'h0, "status in reset");
        check("R1", {3'b0, fault_pulse}, 4'h0, "pulse in reset");
        @(negedge clk); rst = 1'b0;
        cur_tag = "R1"; idle();

        cur_tag = "R11"; acc(32'h4000_0004, 2'd2, 1'b0, 1'b1);  // clean word
        acc(32'h0800_0100, 2'd2, 1'b1, 1'b0);                    // clean flash word

        cur_tag = "R2"; acc(32'h4000_2004, 2'd0, 1'b1, 1'b1);   // byte in periph
        idle(); clear_all();
        acc(32'h4000_3010, 2'd1, 1'b0, 1'b1);                    // half in periph
        clear_all();

        cur_tag = "R3"; acc(32'h2000_0101, 2'd1, 1'b0, 1'b1);   // odd half in RAM
        clear_all();
        acc(32'h0800_0002, 2'd2, 1'b0, 1'b1);                    // word offset 2
        clear_all();
        acc(32'h0800_0003, 2'd3, 1'b0, 1'b1);                    // code 3 as word
        clear_all();
        acc(32'h2000_0102, 2'd1, 1'b0, 1'b1);                    // aligned half, clean

        cur_tag = "R4"; acc(32'h4000_1008, 2'd2, 1'b1, 1'b0);   // user write system periph
        clear_all();
        acc(32'h2000_0010, 2'd2, 1'b1, 1'b0);                    // user write prot RAM
        clear_all();

        cur_tag = "R5"; acc(32'h4000_0008, 2'd2, 1'b0, 1'b0);   // user read system
        acc(32'h2000_00FC, 2'd2, 1'b0, 1'b0);                    // user read prot RAM
        acc(32'h4000_0008, 2'd2, 1'b1, 1'b1);                    // priv write
        acc(32'h4000_2008, 2'd2, 1'b1, 1'b0);                    // user write non-system
        acc(32'h2000_0100, 2'd2, 1'b1, 1'b0);                    // just above prot range

        cur_tag = "R6"; acc(32'h4000_0040, 2'd2, 1'b0, 1'b1);   // past last 0x03C
        clear_all();
        acc(32'h4000_003C, 2'd2, 1'b0, 1'b1);                    // last register, clean

        cur_tag = "R7"; acc(32'h2000_2000, 2'd2, 1'b0, 1'b1);
        clear_all();
        acc(32'h0802_0000, 2'd2, 1'b1, 1'b1);
        clear_all();
        acc(32'h2000_1FFC, 2'd2, 1'b0, 1'b1);                    // top word, clean

        cur_tag = "R8"; acc(32'h4000_1200, 2'd0, 1'b1, 1'b0);   // size+priv+hole
        clear_all();

        cur_tag = "R9"; acc(32'h4000_2001, 2'd0, 1'b0, 1'b1);
        acc(32'h2000_3000, 2'd2, 1'b0, 1'b1);                    // second fault
        clear_all();
        acc(32'h4000_2001, 2'd0, 1'b0, 1'b1);

        cur_tag = "R10";
        cycle(1'b1, 32'h0802_0000, 2'd2, 1'b0, 1'b1, 1'b1, 4'hF); // clear+set same edge
        repeat (3) idle();
        cycle(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 4'h8);        // partial clear
        cycle(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 4'h0);        // empty mask
        clear_all();

        cur_tag = "R11"; acc(32'h4000_0041, 2'd1, 1'b1, 1'b0);
        acc(32'h4000_0000, 2'd2, 1'b0, 1'b1);
        clear_all();

        cur_tag = "R8";
        for (int k = 0; k < 600; k++) begin
            logic [31:0] pool [12] = '{32'h4000_0000, 32'h4000_0040, 32'h4000_1000,
                32'h4000_10FC, 32'h4000_2018, 32'h4000_3080, 32'h2000_0000,
                32'h2000_00FC, 32'h2000_1FFC, 32'h2000_2000, 32'h0801_FFFC, 32'h0802_0000};
            logic [31:0] a;
            a = pool[$urandom_range(0, 11)] + 32'($urandom_range(0, 3));
            cycle(1'($urandom_range(0, 3) != 0), a, 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 4) == 0), 4'($urandom_range(0, 15)));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule